// File: doc/BRIEF.md
# SPI-Addressed Byte-Wide GPIO Expander Core

This block is the register-side logic of a general-purpose I/O expander that sits on an SPI bus in mode 0 (clock idles low, data sampled on the rising edge, MSB first). A host selects the block with an active-low chip select. It then sends an opcode byte and a register index byte, followed by one or more data bytes that are either written into the block or read back on MISO. Eight pins are controlled: per-pin direction (turned into output enables), pull-up enables, the output latch, and an input polarity mask applied when the port is read. Several of these blocks can share one chip select, because the opcode carries a 3-bit hardware address that is compared against strap inputs when address checking is turned on.

The SPI pins are oversampled in the system clock domain, so SCK must run well below the system clock. The configuration register controls two things: whether the register index advances after each data byte, and whether the opcode address is checked against the straps. Interrupt generation is done by a neighbouring block. This core only stores the interrupt enable, compare value and control masks and drives them out. It returns that block's flag and capture bytes when the host reads them.

Top module: `gpx_spi_expander`

## Requirements
- R1: After reset the direction register is 0xFF, so `pad_oe` is 0x00. The output latch, pull-up, polarity, interrupt and configuration registers are all 0x00, so `pad_out`, `pad_pull_en`, `irq_en_o`, `irq_defval_o`, `irq_ctl_o` and `cfg_o` read 0x00.
- R2: A frame is accepted only if its first byte has the upper nibble 0b0100; bits 3..1 are a hardware address and bit 0 set means read. Any other upper nibble makes the rest of the frame ignored: no register changes and read bytes are 0x00.
- R3: When configuration bit 3 (address check) is 1, a frame whose opcode address bits differ from `hw_addr` is ignored in the same way as R2.
- R4: When configuration bit 3 is 0, the opcode address bits are ignored and every frame with the 0b0100 prefix is accepted.
- R5: In a write frame, byte 2 is the register index (0x00 direction, 0x01 polarity, 0x02 interrupt enable, 0x03 compare value, 0x04 interrupt control, 0x05 configuration, 0x06 pull-up, 0x07 flag, 0x08 capture, 0x09 port, 0x0A output latch) and byte 3 is the data. A direction bit of 0 makes that pin an output (`pad_oe` bit 1). `pad_out` shows the output latch and `pad_pull_en` shows the pull-up register.
- R6: In a read frame, the bytes after the two header bytes return register contents on `spi_miso`, MSB first. MISO changes only after falling SCK edges, so it is stable around each rising edge.
- R7: Reading the port register (0x09) returns `pad_in` XOR the polarity register. Writing the port register loads the output latch.
- R8: With configuration bit 5 at 0, the register index advances after each data byte of both reads and writes, and wraps from 0x0A to 0x00.
- R9: With configuration bit 5 at 1, the register index stays fixed for the whole frame, so repeated data bytes all address one register.
- R10: Writes to 0x07 and 0x08 are ignored; reading them returns `irq_flag_i` and `irq_cap_i`. Indices above 0x0A read 0x00, and writes to them are ignored.
- R11: Configuration bits 7 and 4 are always 0. `cfg_o`, `irq_en_o`, `irq_defval_o` and `irq_ctl_o` follow their registers.
- R12: Raising chip select aborts the frame. A partly shifted byte is dropped, and the next selection starts again with an opcode byte. While the block is deselected it changes no output, and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, held low while deselected |
| hw_addr | input | 3 | Hardware address straps |
| pad_in | input | 8 | Sampled pin levels |
| pad_out | output | 8 | Output latch value driven onto the pins |
| pad_oe | output | 8 | Per-pin output enable (inverse of direction) |
| pad_pull_en | output | 8 | Per-pin pull-up enable |
| irq_flag_i | input | 8 | Flag byte from the interrupt block |
| irq_cap_i | input | 8 | Capture byte from the interrupt block |
| irq_en_o | output | 8 | Stored per-pin interrupt enable |
| irq_defval_o | output | 8 | Stored compare value |
| irq_ctl_o | output | 8 | Stored interrupt control mask |
| cfg_o | output | 8 | Configuration register |

## Verification
Single-register writes are checked at the pin outputs, which separates direction, latch and pull-up decoding. An eleven-byte sequential read from index 0 tells each stored register apart from the pass-through flag and capture bytes and from the polarity-adjusted port view. A read that starts at 0x0A shows the wrap of the index, and the same multi-byte frames sent again with sequential mode off show that the index stays fixed. Opcodes with the wrong prefix or the wrong address, sent with the address check both on and off, and frames cut short mid-byte show that rejected and aborted traffic leaves the pins untouched.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int unsigned GPX_W = 8;
   localparam logic [3:0] GPX_PREFIX = 4'b0100;

   localparam logic [7:0] RA_DIR  = 8'h00;
   localparam logic [7:0] RA_IPOL = 8'h01;
   localparam logic [7:0] RA_IEN  = 8'h02;
   localparam logic [7:0] RA_IDEF = 8'h03;
   localparam logic [7:0] RA_ICTL = 8'h04;
   localparam logic [7:0] RA_CFG  = 8'h05;
   localparam logic [7:0] RA_PUP  = 8'h06;
   localparam logic [7:0] RA_IFLG = 8'h07;
   localparam logic [7:0] RA_ICAP = 8'h08;
   localparam logic [7:0] RA_PORT = 8'h09;
   localparam logic [7:0] RA_OLAT = 8'h0A;

   localparam int unsigned CFG_SEQ_OFF = 5;
   localparam int unsigned CFG_ADDR_EN = 3;
   localparam logic [7:0] CFG_WMASK = 8'h6F;

   typedef enum logic [1:0] {
      ST_OP,
      ST_REG,
      ST_DATA,
      ST_SKIP
   } frame_st_e;
endpackage

// File: rtl/gpx_spi_phy.sv
module gpx_spi_phy #(
   parameter int unsigned W           = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sck,
   input  logic         cs_n,
   input  logic         mosi,
   input  logic         load_en,
   input  logic [W-1:0] load_data,
   output logic         miso,
   output logic         sel,
   output logic         byte_done,
   output logic [W-1:0] rx_byte
);
   localparam int unsigned CW = $clog2(W);
   localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpx_spi_phy: SYNC_STAGES must be at least 2");
      end
      if (W < 3) begin : g_bad_width
         $error("gpx_spi_phy: W must be at least 3");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sck_s, cs_s, mosi_s;
   logic          sck_d;
   logic [CW-1:0] bit_cnt;
   logic [W-2:0]  rx_sh;
   logic [W-1:0]  tx_sh;
   logic          sck_now, mosi_now, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_s  <= '0;
         cs_s   <= '1;
         mosi_s <= '0;
      end else begin
         sck_s  <= {sck_s[SYNC_STAGES-2:0], sck};
         cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
         mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
      end
   end

   assign sck_now  = sck_s[SYNC_STAGES-1];
   assign mosi_now = mosi_s[SYNC_STAGES-1];
   assign sel      = ~cs_s[SYNC_STAGES-1];
   assign rise     = sck_now & ~sck_d;
   assign fall     = ~sck_now & sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
      end else begin
         sck_d <= sck_now;
         if (!sel) begin
            bit_cnt <= '0;
         end else if (rise) begin
            rx_sh   <= {rx_sh[W-3:0], mosi_now};
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (sel && fall) begin
            if (bit_cnt == '0) tx_sh <= load_en ? load_data : '0;
            else               tx_sh <= {tx_sh[W-2:0], 1'b0};
         end
      end
   end

   assign byte_done = sel & rise & (bit_cnt == LAST_BIT);
   assign rx_byte   = {rx_sh, mosi_now};
   assign miso      = sel & tx_sh[W-1];
endmodule

// File: rtl/gpx_frame_ctl.sv
module gpx_frame_ctl
   import gpx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       byte_done,
   input  logic [7:0] rx_byte,
   input  logic [2:0] hw_addr,
   input  logic       addr_chk_en,
   input  logic       seq_off,
   output logic       wr_en,
   output logic       rd_phase,
   output logic [7:0] ptr
);
   frame_st_e state;
   logic      rw_q;
   logic      op_ok;

   assign op_ok = (rx_byte[7:4] == GPX_PREFIX) &&
                  (!addr_chk_en || (rx_byte[3:1] == hw_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_OP;
         rw_q  <= 1'b0;
         ptr   <= '0;
      end else if (!sel) begin
         state <= ST_OP;
      end else if (byte_done) begin
         unique case (state)
            ST_OP: begin
               rw_q  <= rx_byte[0];
               state <= op_ok ? ST_REG : ST_SKIP;
            end
            ST_REG: begin
               ptr   <= rx_byte;
               state <= ST_DATA;
            end
            ST_DATA: begin
               if (!seq_off) ptr <= (ptr == RA_OLAT) ? 8'h00 : ptr + 8'd1;
            end
            default: state <= ST_SKIP;
         endcase
      end
   end

   assign wr_en    = byte_done && (state == ST_DATA) && !rw_q;
   assign rd_phase = (state == ST_DATA) && rw_q;
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
   import gpx_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [7:0]   addr,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] pad_in,
   input  logic [W-1:0] irq_flag_i,
   input  logic [W-1:0] irq_cap_i,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] ien_q,
   output logic [W-1:0] idef_q,
   output logic [W-1:0] ictl_q,
   output logic [W-1:0] cfg_q,
   output logic [W-1:0] pup_q,
   output logic [W-1:0] olat_q
);
   logic [W-1:0] ipol_q;
   logic [W-1:0] port_view;

   for (genvar i = 0; i < W; i++) begin : g_pin_view
      assign port_view[i] = pad_in[i] ^ ipol_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         ipol_q <= '0;
         ien_q  <= '0;
         idef_q <= '0;
         ictl_q <= '0;
         cfg_q  <= '0;
         pup_q  <= '0;
         olat_q <= '0;
      end else if (wr_en) begin
         case (addr)
            RA_DIR:  dir_q  <= wr_data;
            RA_IPOL: ipol_q <= wr_data;
            RA_IEN:  ien_q  <= wr_data;
            RA_IDEF: idef_q <= wr_data;
            RA_ICTL: ictl_q <= wr_data;
            RA_CFG:  cfg_q  <= wr_data & CFG_WMASK;
            RA_PUP:  pup_q  <= wr_data;
            RA_PORT,
            RA_OLAT: olat_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         RA_DIR:  rd_data = dir_q;
         RA_IPOL: rd_data = ipol_q;
         RA_IEN:  rd_data = ien_q;
         RA_IDEF: rd_data = idef_q;
         RA_ICTL: rd_data = ictl_q;
         RA_CFG:  rd_data = cfg_q;
         RA_PUP:  rd_data = pup_q;
         RA_IFLG: rd_data = irq_flag_i;
         RA_ICAP: rd_data = irq_cap_i;
         RA_PORT: rd_data = port_view;
         RA_OLAT: rd_data = olat_q;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpx_spi_expander.sv
module gpx_spi_expander
   import gpx_pkg::*;
#(
   parameter int unsigned PIN_COUNT   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sck,
   input  logic                 spi_cs_n,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   input  logic [2:0]           hw_addr,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic [PIN_COUNT-1:0] pad_oe,
   output logic [PIN_COUNT-1:0] pad_pull_en,
   input  logic [PIN_COUNT-1:0] irq_flag_i,
   input  logic [PIN_COUNT-1:0] irq_cap_i,
   output logic [PIN_COUNT-1:0] irq_en_o,
   output logic [PIN_COUNT-1:0] irq_defval_o,
   output logic [PIN_COUNT-1:0] irq_ctl_o,
   output logic [PIN_COUNT-1:0] cfg_o
);
   generate
      if (PIN_COUNT != GPX_W) begin : g_bad_pins
         $error("gpx_spi_expander: PIN_COUNT must match the byte-wide register width");
      end
   endgenerate

   logic                 sel, byte_done, wr_en, rd_phase;
   logic [GPX_W-1:0]     rx_byte;
   logic [7:0]           ptr;
   logic [PIN_COUNT-1:0] rd_data, dir_q;

   gpx_spi_phy #(.W(GPX_W), .SYNC_STAGES(SYNC_STAGES)) i_phy (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck       (spi_sck),
      .cs_n      (spi_cs_n),
      .mosi      (spi_mosi),
      .load_en   (rd_phase),
      .load_data (rd_data),
      .miso      (spi_miso),
      .sel       (sel),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   gpx_frame_ctl i_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (sel),
      .byte_done   (byte_done),
      .rx_byte     (rx_byte),
      .hw_addr     (hw_addr),
      .addr_chk_en (cfg_o[CFG_ADDR_EN]),
      .seq_off     (cfg_o[CFG_SEQ_OFF]),
      .wr_en       (wr_en),
      .rd_phase    (rd_phase),
      .ptr         (ptr)
   );

   gpx_regfile #(.W(PIN_COUNT)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (ptr),
      .wr_data    (rx_byte),
      .pad_in     (pad_in),
      .irq_flag_i (irq_flag_i),
      .irq_cap_i  (irq_cap_i),
      .rd_data    (rd_data),
      .dir_q      (dir_q),
      .ien_q      (irq_en_o),
      .idef_q     (irq_defval_o),
      .ictl_q     (irq_ctl_o),
      .cfg_q      (cfg_o),
      .pup_q      (pad_pull_en),
      .olat_q     (pad_out)
   );

   assign pad_oe = ~dir_q;
endmodule

// File: rtl/gpx_spi_expander_chk.sv
module gpx_spi_expander_chk #(
   parameter int unsigned PIN_COUNT   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 spi_sck,
   input logic                 spi_cs_n,
   input logic                 spi_miso,
   input logic [PIN_COUNT-1:0] pad_out,
   input logic [PIN_COUNT-1:0] pad_oe,
   input logic [PIN_COUNT-1:0] pad_pull_en,
   input logic [PIN_COUNT-1:0] cfg_o
);
   localparam int unsigned SETTLE = SYNC_STAGES + 3;

   logic [7:0] idle_cnt, quiet_cnt;
   logic       sck_p, cs_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt  <= '0;
         quiet_cnt <= '0;
         sck_p     <= 1'b0;
         cs_p      <= 1'b1;
      end else begin
         sck_p <= spi_sck;
         cs_p  <= spi_cs_n;
         if (!spi_cs_n)             idle_cnt <= '0;
         else if (idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 8'd1;
         if ((spi_sck != sck_p) || (spi_cs_n != cs_p)) quiet_cnt <= '0;
         else if (quiet_cnt != 8'hFF)                   quiet_cnt <= quiet_cnt + 8'd1;
      end
   end

   AST_RESET_PINS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_pull_en == '0 && cfg_o == '0)); // R1

   AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cnt >= SETTLE) |=> ($stable(pad_out) && $stable(pad_oe) &&
                                $stable(pad_pull_en) && $stable(cfg_o))); // R12

   AST_DESELECT_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cnt >= SETTLE) |-> !spi_miso); // R12

   AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt >= SETTLE) |=> $stable(spi_miso)); // R6
endmodule

bind gpx_spi_expander gpx_spi_expander_chk #(
   .PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spi_sck     (spi_sck),
   .spi_cs_n    (spi_cs_n),
   .spi_miso    (spi_miso),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .pad_pull_en (pad_pull_en),
   .cfg_o       (cfg_o)
);

// File: tb/test_gpx_spi_expander.sv
`timescale 1ns/1ps
module test_gpx_spi_expander;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic       spi_miso;
   logic [2:0] hw_addr = 3'd3;
   logic [7:0] pad_in = 8'h00, irq_flag_i = 8'h00, irq_cap_i = 8'h00;
   logic [7:0] pad_out, pad_oe, pad_pull_en, irq_en_o, irq_defval_o, irq_ctl_o, cfg_o;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [7:0] txd [0:15];
   logic [7:0] got_q [$];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   event       got_ev;

   always #2 clk = ~clk;

   gpx_spi_expander i_gpx_spi_expander (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .hw_addr(hw_addr), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
      .irq_flag_i(irq_flag_i), .irq_cap_i(irq_cap_i), .irq_en_o(irq_en_o),
      .irq_defval_o(irq_defval_o), .irq_ctl_o(irq_ctl_o), .cfg_o(cfg_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic expect_rd(input string tag, input logic [7:0] v);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   // scoreboard monitor: pairs each captured MISO byte with the next expected item
   initial forever begin
      @(got_ev);
      while (got_q.size() > 0) begin
         logic [7:0] g;
         g = got_q.pop_front();
         if (exp_q.size() == 0) chk("unexpected read byte", g, 8'hxx);
         else chk(tag_q.pop_front(), g, exp_q.pop_front());
      end
   end

   task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 0; i < nb; i++) begin
         spi_mosi = tx[7-i];
         repeat (HALF) @(negedge clk);
         rx[7-i] = spi_miso;
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
   endtask

   task automatic frame(input logic [7:0] op, input logic [7:0] ra, input int n);
      logic [7:0] r;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      xbits(op, 8, r);
      xbits(ra, 8, r);
      for (int k = 0; k < n; k++) begin
         xbits(txd[k], 8, r);
         if (op[0]) begin
            got_q.push_back(r);
            -> got_ev;
         end
      end
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic wr1(input logic [7:0] op, input logic [7:0] ra, input logic [7:0] d);
      txd[0] = d;
      frame(op, ra, 1);
   endtask

   task automatic rdn(input logic [7:0] op, input logic [7:0] ra, input int n);
      for (int k = 0; k < n; k++) txd[k] = 8'h00;
      frame(op, ra, n);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 pad_oe", pad_oe, 8'h00);
      chk("R1 pad_out", pad_out, 8'h00);
      chk("R1 pull", pad_pull_en, 8'h00);
      chk("R1 cfg", cfg_o, 8'h00);
      chk("R1 ien", irq_en_o, 8'h00);

      // R4: address check off, opcode address 5 differs from straps 3 but is accepted
      wr1(8'h4A, 8'h00, 8'hF0);
      chk("R4/R5 pad_oe", pad_oe, 8'h0F);
      wr1(8'h40, 8'h0A, 8'hA5);
      chk("R5 pad_out", pad_out, 8'hA5);
      wr1(8'h40, 8'h06, 8'h3C);
      chk("R5 pull", pad_pull_en, 8'h3C);

      // R8: sequential write 0x01..0x04
      txd[0] = 8'h0F; txd[1] = 8'h81; txd[2] = 8'h55; txd[3] = 8'h22;
      frame(8'h40, 8'h01, 4);
      chk("R11 ien", irq_en_o, 8'h81);
      chk("R11 defval", irq_defval_o, 8'h55);
      chk("R11 ictl", irq_ctl_o, 8'h22);

      // R6/R7/R8/R10: one burst read of the whole map
      pad_in = 8'h96; irq_flag_i = 8'h12; irq_cap_i = 8'h34;
      expect_rd("R6 dir", 8'hF0);   expect_rd("R8 ipol", 8'h0F);
      expect_rd("R8 ien", 8'h81);   expect_rd("R8 def", 8'h55);
      expect_rd("R8 ictl", 8'h22);  expect_rd("R8 cfg", 8'h00);
      expect_rd("R8 pup", 8'h3C);   expect_rd("R10 flag", 8'h12);
      expect_rd("R10 cap", 8'h34);  expect_rd("R7 port", 8'h99);
      expect_rd("R8 olat", 8'hA5);
      rdn(8'h41, 8'h00, 11);

      // R10: writes to flag/capture ignored
      txd[0] = 8'hFF; txd[1] = 8'hEE;
      frame(8'h40, 8'h07, 2);
      expect_rd("R10 flag after write", 8'h12);
      expect_rd("R10 cap after write", 8'h34);
      rdn(8'h41, 8'h07, 2);

      // R7: port write loads latch
      wr1(8'h40, 8'h09, 8'h3C);
      chk("R7 port write", pad_out, 8'h3C);

      // R8: wrap 0x0A -> 0x00
      expect_rd("R8 wrap olat", 8'h3C);
      expect_rd("R8 wrap dir", 8'hF0);
      expect_rd("R8 wrap ipol", 8'h0F);
      rdn(8'h41, 8'h0A, 3);

      // R10: out-of-range index
      wr1(8'h40, 8'h0B, 8'hFF);
      chk("R10 oor pad_out", pad_out, 8'h3C);
      chk("R10 oor pad_oe", pad_oe, 8'h0F);
      expect_rd("R10 oor read", 8'h00);
      rdn(8'h41, 8'h0B, 1);

      // R11: configuration all ones -> reserved bits zero, seq off, addr check on
      wr1(8'h40, 8'h05, 8'hFF);
      chk("R11 cfg_o", cfg_o, 8'h6F);
      expect_rd("R11 cfg read", 8'h6F);
      rdn(8'h47, 8'h05, 1);

      // R9: index fixed
      expect_rd("R9 fixed 0", 8'hF0);
      expect_rd("R9 fixed 1", 8'hF0);
      expect_rd("R9 fixed 2", 8'hF0);
      rdn(8'h47, 8'h00, 3);
      txd[0] = 8'h11; txd[1] = 8'h22;
      frame(8'h46, 8'h0A, 2);
      chk("R9 last write wins", pad_out, 8'h22);
      chk("R9 dir untouched", pad_oe, 8'h0F);

      // R3: address check on
      wr1(8'h4A, 8'h0A, 8'h77);
      chk("R3 wrong addr write", pad_out, 8'h22);
      expect_rd("R3 wrong addr read", 8'h00);
      rdn(8'h4B, 8'h0A, 1);
      wr1(8'h46, 8'h0A, 8'h77);
      chk("R3 right addr write", pad_out, 8'h77);

      // R2: bad prefix
      wr1(8'h26, 8'h0A, 8'h55);
      chk("R2 prefix 0010", pad_out, 8'h77);
      wr1(8'hC6, 8'h0A, 8'h55);
      chk("R2 prefix 1100", pad_out, 8'h77);
      expect_rd("R2 bad prefix read", 8'h00);
      rdn(8'h57, 8'h0A, 1);

      // R4: address check back off, any address accepted
      wr1(8'h46, 8'h05, 8'h00);
      chk("R4 cfg cleared", cfg_o, 8'h00);
      wr1(8'h4E, 8'h0A, 8'h99);
      chk("R4 addr 7 accepted", pad_out, 8'h99);

      // R12: abort mid-opcode, then full frame
      @(negedge clk); spi_cs_n = 1'b0; repeat (HALF) @(negedge clk);
      xbits(8'h40, 4, r);
      repeat (HALF) @(negedge clk); spi_cs_n = 1'b1; repeat (12) @(negedge clk);
      chk("R12 deselected miso", {7'd0, spi_miso}, 8'h00);
      wr1(8'h40, 8'h0A, 8'h5A);
      chk("R12 frame after abort", pad_out, 8'h5A);
      // R12: abort mid-data byte
      @(negedge clk); spi_cs_n = 1'b0; repeat (HALF) @(negedge clk);
      xbits(8'h40, 8, r); xbits(8'h0A, 8, r); xbits(8'hC3, 4, r);
      repeat (HALF) @(negedge clk); spi_cs_n = 1'b1; repeat (12) @(negedge clk);
      chk("R12 partial data dropped", pad_out, 8'h5A);
      wr1(8'h40, 8'h06, 8'h81);
      chk("R12 restart pull", pad_pull_en, 8'h81);

      repeat (20) @(negedge clk);
      while (exp_q.size() > 0) begin
         checks++;
         failures++;
         $display("FAIL %s: got none expected %02h", tag_q.pop_front(), exp_q.pop_front());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule